// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, one frame at a time, whether an incoming Ethernet frame should be kept. For each frame the MAC presents the 6-byte destination address and the frame length together with a start strobe. A fixed number of cycles later the block returns a verdict: accept or reject, and a flag that marks accepted group traffic (broadcast or multicast). The verdict depends on a minimum-length gate, a promiscuous switch, a broadcast gate, a multicast gate backed by a 64-bin hash table, and an exact match against the station address.

The hash table is filled through a separate load path. A load strobe carries the list length in bytes. The block wipes the table and then absorbs one multicast address per valid beat until the listed number of addresses has been taken. Each absorbed address sets the bin picked by its CRC-32 hash. The station address and the configuration bits are plain inputs held by surrounding registers.

Top module: `rx_addr_filter`

## Requirements
- R1: Reset is synchronous and active low. After a clock edge with `rst_n` low, `dec_valid`, `dec_accept`, `dec_group` and `load_busy` are 0 and every hash bin is clear.
- R2: On a rising edge where `dec_start` is 1, the block samples `dec_dst`, `dec_len`, `sta_addr` and all `cfg_*` inputs. The verdict is driven after the following rising edge, with `dec_valid` high for exactly that one cycle. A new start may be given every cycle. `dec_accept` and `dec_group` are 0 whenever `dec_valid` is 0.
- R3: The effective minimum length is the larger of `cfg_min_len` and 5. A frame whose `dec_len` is below it is rejected with `dec_group` 0, whatever the address or mode.
- R4: With `cfg_promisc` set, every frame that passes R3 is accepted with `dec_group` 0.
- R5: A destination of all ones is broadcast. It is rejected when `cfg_bc_disable` is 1. Otherwise it is accepted with `dec_group` 1.
- R6: The first address byte is `dec_dst[47:40]`. A non-broadcast destination with `dec_dst[40]` set is multicast. It is rejected when `cfg_mc_enable` is 0. Otherwise it is accepted, with `dec_group` 1, only if its hash bin is set. The bin is read as it stands after the edge that samples `dec_start`.
- R7: A destination with `dec_dst[40]` clear is accepted, with `dec_group` 0, only when all 48 bits equal `sta_addr`. Otherwise it is rejected.
- R8: The hash bin of an address is bits 7..2 of a CRC-32 register that starts at all ones. The register is clocked over the six address bytes, first byte first and each byte least-significant bit first. Each step shifts left and XORs in 0x04C11DB7 when the outgoing top bit differs from the input bit. There is no final inversion.
- R9: A `load_start` edge clears all 64 bins and sets the entry budget to `load_bytes` / 6 (integer division), capped at 64. `load_busy` is 1 exactly while the budget is non-zero.
- R10: Each `mc_valid` edge while `load_busy` is 1 (and `load_start` is 0) sets the bin of `mc_addr` and uses up one entry. An `mc_valid` edge while `load_busy` is 0, or together with `load_start`, changes no bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_promisc | input | 1 | Accept every frame of legal length |
| cfg_bc_disable | input | 1 | Reject broadcast frames |
| cfg_mc_enable | input | 1 | Allow hashed multicast acceptance |
| cfg_min_len | input | 8 | Configured minimum frame length (floor of 5 applied) |
| sta_addr | input | 48 | Station address, first byte in bits 47:40 |
| load_start | input | 1 | Begin a new multicast list, clearing the table |
| load_bytes | input | 16 | Length of the new list in bytes |
| mc_valid | input | 1 | A list entry is present on `mc_addr` |
| mc_addr | input | 48 | Multicast list entry, first byte in bits 47:40 |
| load_busy | output | 1 | List entries are still expected |
| dec_start | input | 1 | A frame is presented for a verdict |
| dec_dst | input | 48 | Destination address, first byte in bits 47:40 |
| dec_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Verdict present this cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_group | output | 1 | Accepted frame is broadcast or multicast |

## Verification
The bench builds the block with its defaults: 64 hash bins, a 64-entry budget, 16-bit length and count fields, and an 8-bit minimum. At these values a 420-byte list runs past the 64-entry cap, so the budget clamp and the stray beats that follow it can be observed. The 8-bit minimum lets the 5-byte floor be checked against settings of 0 and 64. With 64 bins, several listed addresses and unlisted probes give both hits and misses, and some probes land on shared bins.

// File: rtl/raf_pkg.sv
// Shared constants, types and the address hash function for the
// receive address filter. Assumes addresses carry their first byte in
// the top eight bits.
package raf_pkg;

    localparam int MAC_W       = 48;
    localparam int MAC_BYTES   = 6;
    localparam int ENTRY_BYTES = 6;
    localparam int LEN_FLOOR   = 5;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    typedef logic [MAC_W-1:0] mac_t;

    // Which rule settled a frame's verdict
    typedef enum logic [2:0] {
        CLS_SHORT = 3'd0,
        CLS_ALL   = 3'd1,
        CLS_BCAST = 3'd2,
        CLS_GROUP = 3'd3,
        CLS_UNI   = 3'd4
    } frame_cls_e;

    // CRC register over the six address bytes, first byte first, each byte
    // least-significant bit first, starting from all ones, no final inversion.
    function automatic logic [31:0] mac_crc(input mac_t mac);
        logic [31:0] c;
        logic        fb;
        c = '1;
        for (int i = 0; i < MAC_BYTES; i++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ mac[MAC_W - 8*(i+1) + b];
                c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/raf_hash_index.sv
// Maps an address to its hash bin: CRC bits starting at bit 2.
// Purely combinational; assumes HASH_W <= 30.
module raf_hash_index
    import raf_pkg::*;
#(
    parameter int HASH_W = 6
) (
    input  mac_t              mac,
    output logic [HASH_W-1:0] bin
);

    // Pick the bin field out of the address CRC
    assign bin = HASH_W'(mac_crc(mac) >> 2);

endmodule

// File: rtl/raf_mcast_table.sv
// Multicast hash table and its load path. A load strobe clears every bin
// and arms an entry budget of bytes/6 (capped); each valid entry beat
// inside the budget sets one bin. Assumes the list arrives after the strobe.
module raf_mcast_table
    import raf_pkg::*;
#(
    parameter int TBL_BITS    = 64,
    parameter int MAX_ENTRIES = 64,
    parameter int CNT_W       = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_start,
    input  logic [CNT_W-1:0]    load_bytes,
    input  logic                mc_valid,
    input  mac_t                mc_addr,
    output logic                load_busy,
    output logic [TBL_BITS-1:0] table_bits
);

    localparam int HASH_W = $clog2(TBL_BITS);
    localparam int REM_W  = $clog2(MAX_ENTRIES + 1);

    logic [CNT_W-1:0]  n_listed;
    logic [REM_W-1:0]  n_take;
    logic [REM_W-1:0]  remaining;
    logic [HASH_W-1:0] entry_bin;
    logic              set_en;

    // Number of whole addresses in the list, clamped to the budget
    assign n_listed = load_bytes / CNT_W'(ENTRY_BYTES);
    assign n_take   = (n_listed > CNT_W'(MAX_ENTRIES)) ? REM_W'(MAX_ENTRIES)
                                                       : REM_W'(n_listed);

    assign load_busy = (remaining != '0);
    assign set_en    = mc_valid && load_busy && !load_start;

    raf_hash_index #(.HASH_W(HASH_W)) u_entry_hash (
        .mac (mc_addr),
        .bin (entry_bin)
    );

    // Entry budget: armed by the strobe, spent one per accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n)          remaining <= '0;
        else if (load_start) remaining <= n_take;
        else if (set_en)     remaining <= remaining - 1'b1;
    end

    // Hash bins: cleared by the strobe, set by entries inside the budget
    always_ff @(posedge clk) begin
        if (!rst_n || load_start) begin
            table_bits <= '0;
        end else if (set_en) begin
            for (int k = 0; k < TBL_BITS; k++) begin
                if (entry_bin == HASH_W'(k)) table_bits[k] <= 1'b1;
            end
        end
    end

    // R9: a load strobe leaves an empty table behind it
    a_r9_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_start) |-> (table_bits == '0));

    // R9: at most one new bin per cycle outside a load strobe
    a_r9_one_bin_per_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !load_start) |->
            ($countones(table_bits) <= $countones($past(table_bits)) + 1));

    // R10: beats outside the budget leave the table untouched
    a_r10_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !load_busy && !load_start) |-> $stable(table_bits));

endmodule

// File: rtl/raf_decide.sv
// Per-frame verdict path. Stage one captures the frame and configuration
// on the start strobe; stage two classifies it, looks up the hash bin and
// registers accept/group with a one-cycle valid. Assumes LEN_W >= MIN_W.
module raf_decide
    import raf_pkg::*;
#(
    parameter int TBL_BITS = 64,
    parameter int LEN_W    = 16,
    parameter int MIN_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_start,
    input  mac_t                dec_dst,
    input  logic [LEN_W-1:0]    dec_len,
    input  mac_t                sta_addr,
    input  logic                cfg_promisc,
    input  logic                cfg_bc_disable,
    input  logic                cfg_mc_enable,
    input  logic [MIN_W-1:0]    cfg_min_len,
    input  logic [TBL_BITS-1:0] table_bits,
    output logic                dec_valid,
    output logic                dec_accept,
    output logic                dec_group
);

    localparam int HASH_W = $clog2(TBL_BITS);

    logic              s1_v;
    mac_t              s1_dst;
    mac_t              s1_sta;
    logic [LEN_W-1:0]  s1_len;
    logic [MIN_W-1:0]  s1_min;
    logic              s1_pr;
    logic              s1_bcd;
    logic              s1_mce;

    logic [MIN_W-1:0]  eff_min;
    logic              too_short;
    logic [HASH_W-1:0] dst_bin;
    frame_cls_e        cls;
    logic              acc;
    logic              grp;

    // Stage one: capture the frame and the configuration it is judged by
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_dst <= '0;
            s1_sta <= '0;
            s1_len <= '0;
            s1_min <= '0;
            s1_pr  <= 1'b0;
            s1_bcd <= 1'b0;
            s1_mce <= 1'b0;
        end else begin
            s1_v <= dec_start;
            if (dec_start) begin
                s1_dst <= dec_dst;
                s1_sta <= sta_addr;
                s1_len <= dec_len;
                s1_min <= cfg_min_len;
                s1_pr  <= cfg_promisc;
                s1_bcd <= cfg_bc_disable;
                s1_mce <= cfg_mc_enable;
            end
        end
    end

    raf_hash_index #(.HASH_W(HASH_W)) u_dst_hash (
        .mac (s1_dst),
        .bin (dst_bin)
    );

    // Minimum-length gate with the fixed floor
    assign eff_min   = (s1_min < MIN_W'(LEN_FLOOR)) ? MIN_W'(LEN_FLOOR) : s1_min;
    assign too_short = (s1_len < LEN_W'(eff_min));

    // Classify the frame in rule priority order
    always_comb begin
        if (too_short)             cls = CLS_SHORT;
        else if (s1_pr)            cls = CLS_ALL;
        else if (&s1_dst)          cls = CLS_BCAST;
        else if (s1_dst[MAC_W-8])  cls = CLS_GROUP;
        else                       cls = CLS_UNI;
    end

    // Verdict for the chosen class
    always_comb begin
        acc = 1'b0;
        grp = 1'b0;
        case (cls)
            CLS_ALL:   acc = 1'b1;
            CLS_BCAST: begin
                acc = !s1_bcd;
                grp = !s1_bcd;
            end
            CLS_GROUP: begin
                acc = s1_mce && table_bits[dst_bin];
                grp = s1_mce && table_bits[dst_bin];
            end
            CLS_UNI:   acc = (s1_dst == s1_sta);
            default:   acc = 1'b0;
        endcase
    end

    // Stage two: register the verdict, gated by the valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_group  <= 1'b0;
        end else begin
            dec_valid  <= s1_v;
            dec_accept <= s1_v && acc;
            dec_group  <= s1_v && grp;
        end
    end

    // R2: every verdict traces back to a start two edges earlier
    a_r2_valid_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(dec_start, 2));

    // R2: no verdict bits without a valid
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && !dec_group));

    // R3: short frames never pass
    a_r3_short_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ($past(dec_len, 2) < LEN_W'(LEN_FLOOR))) |-> !dec_accept);

    // R4: promiscuous frames of legal length always pass
    a_r4_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_promisc, 2)
         && ($past(dec_len, 2) >= LEN_W'({MIN_W{1'b1}}))) |-> dec_accept);

    // R5/R6: the group flag only marks accepted frames
    a_r5_group_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        dec_group |-> dec_accept);

endmodule

// File: rtl/rx_addr_filter.sv
// Receive address filter top: joins the multicast table load path and the
// per-frame verdict path. Configuration and station address come from
// registers outside this block.
module rx_addr_filter
    import raf_pkg::*;
#(
    parameter int TBL_BITS    = 64,
    parameter int MAX_ENTRIES = 64,
    parameter int CNT_W       = 16,
    parameter int LEN_W       = 16,
    parameter int MIN_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_promisc,
    input  logic             cfg_bc_disable,
    input  logic             cfg_mc_enable,
    input  logic [MIN_W-1:0] cfg_min_len,
    input  logic [47:0]      sta_addr,
    input  logic             load_start,
    input  logic [CNT_W-1:0] load_bytes,
    input  logic             mc_valid,
    input  logic [47:0]      mc_addr,
    output logic             load_busy,
    input  logic             dec_start,
    input  logic [47:0]      dec_dst,
    input  logic [LEN_W-1:0] dec_len,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_group
);

    logic [TBL_BITS-1:0] table_bits;

    raf_mcast_table #(
        .TBL_BITS    (TBL_BITS),
        .MAX_ENTRIES (MAX_ENTRIES),
        .CNT_W       (CNT_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .load_bytes (load_bytes),
        .mc_valid   (mc_valid),
        .mc_addr    (mc_addr),
        .load_busy  (load_busy),
        .table_bits (table_bits)
    );

    raf_decide #(
        .TBL_BITS (TBL_BITS),
        .LEN_W    (LEN_W),
        .MIN_W    (MIN_W)
    ) u_decide (
        .clk            (clk),
        .rst_n          (rst_n),
        .dec_start      (dec_start),
        .dec_dst        (dec_dst),
        .dec_len        (dec_len),
        .sta_addr       (sta_addr),
        .cfg_promisc    (cfg_promisc),
        .cfg_bc_disable (cfg_bc_disable),
        .cfg_mc_enable  (cfg_mc_enable),
        .cfg_min_len    (cfg_min_len),
        .table_bits     (table_bits),
        .dec_valid      (dec_valid),
        .dec_accept     (dec_accept),
        .dec_group      (dec_group)
    );

endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_promisc = 1'b0, cfg_bc_disable = 1'b0, cfg_mc_enable = 1'b1;
    logic [7:0]  cfg_min_len = 8'd0;
    logic [47:0] sta_addr = 48'h02_11_22_33_44_55;
    logic        load_start = 1'b0;
    logic [15:0] load_bytes = 16'd0;
    logic        mc_valid = 1'b0;
    logic [47:0] mc_addr = 48'h0;
    logic        load_busy;
    logic        dec_start = 1'b0;
    logic [47:0] dec_dst = 48'h0;
    logic [15:0] dec_len = 16'd0;
    logic        dec_valid, dec_accept, dec_group;

    always #2.5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_promisc(cfg_promisc), .cfg_bc_disable(cfg_bc_disable),
        .cfg_mc_enable(cfg_mc_enable), .cfg_min_len(cfg_min_len),
        .sta_addr(sta_addr),
        .load_start(load_start), .load_bytes(load_bytes),
        .mc_valid(mc_valid), .mc_addr(mc_addr), .load_busy(load_busy),
        .dec_start(dec_start), .dec_dst(dec_dst), .dec_len(dec_len),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_group(dec_group)
    );

    int    vectors = 0;
    int    bad = 0;
    bit    done = 1'b0;

    // reference state
    bit [63:0] m_tbl = '0;
    int        m_rem = 0;
    bit        p_v = 0, p_a = 0, p_g = 0;
    string     p_tag = "R2";
    bit        o_v = 0, o_a = 0, o_g = 0;
    string     o_tag = "R2";
    bit        in_reset = 1'b1;

    function automatic int ref_bin(bit [47:0] a);
        bit [31:0] c = 32'hFFFF_FFFF;
        for (int n = 0; n < 6; n++) begin
            bit [7:0] by = 8'((a >> (8 * (5 - n))) & 48'hFF);
            for (int k = 0; k < 8; k++) begin
                bit din = by[k];
                bit top = c[31];
                c = c << 1;
                if (top != din) c = c ^ 32'h04C11DB7;
            end
        end
        return int'((c >> 2) & 32'd63);
    endfunction

    task automatic ref_decide(output bit a, output bit g, output string tag);
        int em = (cfg_min_len < 5) ? 5 : int'(cfg_min_len);
        a = 0; g = 0;
        if (int'(dec_len) < em) tag = "R3";
        else if (cfg_promisc) begin a = 1; tag = "R4"; end
        else if (dec_dst == 48'hFFFF_FFFF_FFFF) begin
            a = !cfg_bc_disable; g = a; tag = "R5";
        end else if (dec_dst[40]) begin
            a = cfg_mc_enable && m_tbl[ref_bin(dec_dst)]; g = a; tag = "R6 R8 R10";
        end else begin
            a = (dec_dst == sta_addr); tag = "R7";
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_tbl = '0; m_rem = 0;
            p_v = 0; p_a = 0; p_g = 0;
            o_v = 0; o_a = 0; o_g = 0;
            in_reset = 1'b1;
        end else begin
            in_reset = 1'b0;
            o_v = p_v; o_a = p_a; o_g = p_g; o_tag = p_tag;
            if (load_start) begin
                m_tbl = '0;
                m_rem = int'(load_bytes) / 6;
                if (m_rem > 64) m_rem = 64;
            end else if (mc_valid && m_rem > 0) begin
                m_tbl[ref_bin(mc_addr)] = 1'b1;
                m_rem--;
            end
            p_v = dec_start;
            if (dec_start) ref_decide(p_a, p_g, p_tag);
            else begin p_a = 0; p_g = 0; end
        end
    endtask

    task automatic cmp(string tag, string what, bit act, bit exp);
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        vectors++;
        cmp(in_reset ? "R1" : "R2", "dec_valid", dec_valid, o_v);
        cmp(in_reset ? "R1" : o_tag, "dec_accept", dec_accept, o_a);
        cmp(in_reset ? "R1" : o_tag, "dec_group", dec_group, o_g);
        cmp(in_reset ? "R1" : "R9", "load_busy", load_busy, m_rem != 0);
    endtask

    task automatic decide(bit [47:0] d, int len);
        dec_start = 1; dec_dst = d; dec_len = 16'(len);
        tick();
        dec_start = 0;
    endtask

    task automatic load(int bytes);
        load_start = 1; load_bytes = 16'(bytes);
        tick();
        load_start = 0;
    endtask

    task automatic feed(bit [47:0] a);
        mc_valid = 1; mc_addr = a;
        tick();
        mc_valid = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL R2 watchdog: actual hung run, expected completion");
            summary();
            $finish;
        end
    end

    localparam bit [47:0] MA = 48'h01_00_5E_00_00_01;
    localparam bit [47:0] MB = 48'h33_33_00_00_00_01;
    localparam bit [47:0] MC = 48'h01_80_C2_00_00_00;
    localparam bit [47:0] MD = 48'h01_AA_BB_CC_DD_EE;

    initial begin
        bit [31:0] lcg = 32'h1234_5678;
        // R1: reset state
        repeat (3) tick();
        rst_n = 1;
        repeat (2) tick();

        // R9/R10: load three entries; beat with the strobe and beat after budget ignored
        mc_valid = 1; mc_addr = MD;
        load(18);
        mc_valid = 0;
        feed(MA); tick(); feed(MB); feed(MC); feed(MD); tick();

        // R6 R8: listed and unlisted multicast
        decide(MA, 64); decide(MB, 64); decide(MC, 64); decide(MD, 64);
        decide(48'h01_12_34_56_78_9A, 64); tick(); tick();
        cfg_mc_enable = 0; decide(MA, 64); tick(); tick(); cfg_mc_enable = 1;

        // R7: unicast hit and miss
        decide(sta_addr, 60); decide(sta_addr ^ 48'h1, 60);
        decide(48'h02_11_22_33_44_54, 60); tick(); tick();

        // R5: broadcast gate
        decide(48'hFFFF_FFFF_FFFF, 60); cfg_bc_disable = 1;
        decide(48'hFFFF_FFFF_FFFF, 60); tick(); tick(); cfg_bc_disable = 0;

        // R4: promiscuous
        cfg_promisc = 1;
        decide(48'h06_00_00_00_00_01, 60); decide(48'hFFFF_FFFF_FFFF, 60);
        decide(MD, 60); decide(MD, 4); tick(); tick();
        cfg_promisc = 0;

        // R3: length floor and configured minimum
        cfg_min_len = 0; decide(sta_addr, 4); decide(sta_addr, 5);
        cfg_min_len = 64; decide(sta_addr, 63); decide(sta_addr, 64);
        decide(48'hFFFF_FFFF_FFFF, 10); tick(); tick();
        cfg_min_len = 0;

        // R9: budget capped at 64 entries
        load(420);
        for (int i = 0; i < 70; i++) feed({8'h01, 8'h5E, 24'h0, 8'(i)});
        for (int i = 0; i < 70; i += 5) decide({8'h01, 8'h5E, 24'h0, 8'(i)}, 64);
        tick(); tick();

        // R9: odd byte count, then an empty list
        load(7); feed(MA); feed(MB); decide(MA, 64); decide(MB, 64); tick(); tick();
        load(0); feed(MA); decide(MA, 64); tick(); tick();

        // Mixed traffic
        load(24); feed(MA); feed(MB); feed(MC); feed(MD);
        for (int i = 0; i < 300; i++) begin
            bit [47:0] d;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            case (lcg[31:29])
                3'd0: d = MA;  3'd1: d = MC;  3'd2: d = sta_addr;
                3'd3: d = 48'hFFFF_FFFF_FFFF;
                default: d = {lcg[15:8], lcg[23:16], lcg, 8'h00};
            endcase
            cfg_promisc    = (lcg[7:4] == 4'h0);
            cfg_bc_disable = lcg[3];
            cfg_mc_enable  = !lcg[2] || lcg[1];
            cfg_min_len    = lcg[0] ? 8'd60 : 8'd0;
            decide(d, 3 + int'(lcg[12:6]));
            if (lcg[28]) tick();
        end
        cfg_promisc = 0;
        tick(); tick(); tick();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule